// File: doc/BRIEF.md
# Integer to Binary64 Converter

This block turns an integer held in a 64-bit register into an IEEE binary64 value. A 2-bit type code says how the register is read: as a signed or unsigned number, 32 or 64 bits wide. A precision select picks one of two result forms:

- a double-precision result;
- a result rounded to binary32 precision and then written exactly in binary64 format.

When rounding is needed, it follows a 2-bit rounding mode input. Beside the value the block gives a 5-bit class code of the result, a round-up flag, an inexact flag and a flag-update enable. The enable tells the status logic whether it may write those fields.

The converter has one register stage. A request taken with `in_valid` high shows up on the outputs, with `out_valid` high, on the next clock. A 32-bit source converted to double precision always fits exactly, so for that case the block drops the flag-update enable and the status fields are left alone. Decode, the register files and condition updates belong to the surrounding pipeline.

Top module: `i2f_conv`

## Requirements
- R1: Type code 0 reads the low 32 bits as signed, 1 as unsigned 32-bit, 2 reads all 64 bits as signed and 3 as unsigned. For codes 0 and 1, bits 63:32 of the input have no effect on any output.
- R2: When `in_single` is 0 and the type code is 0 or 1, the result is exact, `out_flag_we` is 0 and `out_fr` and `out_fi` are 0. In every other case `out_flag_we` is 1.
- R3: Rounding follows `in_rmode`: 00 to nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R4: When `in_single` is 1, the value is rounded to a 24-bit significand and then encoded exactly in binary64, so result bits 28:0 are always zero.
- R5: `out_fi` is 1 exactly when rounding changed the value. `out_fr` is 1 exactly when rounding increased the magnitude. `out_fr` implies `out_fi`.
- R6: `out_class` is computed from the final result: 00100 for a positive normal, 01000 for a negative normal, 00010 for +0.
- R7: A zero input gives +0.0 (all result bits zero), class 00010 and no flags, in every rounding mode and both precisions.
- R8: The signed 64-bit input 0x8000_0000_0000_0000 converts exactly to -2^63 (0xC3E0_0000_0000_0000) with no flags.
- R9: `out_valid` is `in_valid` delayed by one clock, and the outputs hold the result of the request taken on that edge. After reset, `out_valid` is 0 and the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_value | input | 64 | Integer register contents |
| in_type | input | 2 | Source type code (0 s32, 1 u32, 2 s64, 3 u64) |
| in_single | input | 1 | 1 = round to binary32 precision, 0 = double precision |
| in_rmode | input | 2 | Rounding mode (00 RNE, 01 RZ, 10 +inf, 11 -inf) |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Binary64 result |
| out_class | output | 5 | Result class code |
| out_fr | output | 1 | Magnitude increased by rounding |
| out_fi | output | 1 | Result inexact |
| out_flag_we | output | 1 | Status fields may be written |

## Verification
Two events can land on the same cycle: a round-up that carries out of the significand, and the exponent step that carry causes. The round-up also raises both flags. The bench provokes this case with directed inputs:

- all-ones unsigned 64-bit values;
- 2^24-1 plus low bits in single mode.

It also reaches the case through random values under every rounding mode. Each result is judged against a bench model that rounds in the value domain and only then re-encodes. That model must agree on the bumped exponent, the cleared fraction and both flags within the same output cycle.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int INT_W   = 64;
    localparam int POS_W   = $clog2(INT_W);
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int EXP_BIAS = 1023;

    localparam logic [4:0] CLS_POS_NORM = 5'b00100;
    localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
    localparam logic [4:0] CLS_POS_ZERO = 5'b00010;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;

    typedef struct packed {
        logic              valid;
        logic [INT_W-1:0]  result;
        logic [4:0]        cls;
        logic              fr;
        logic              fi;
        logic              flag_we;
    } conv_out_s;
endpackage

// File: rtl/i2f_norm.sv
module i2f_norm
    import i2f_pkg::*;
(
    input  logic [INT_W-1:0] value,
    input  logic [1:0]       int_type,
    output logic             neg,
    output logic             is_zero,
    output logic [POS_W-1:0] msb_pos,
    output logic [INT_W-1:0] norm
);
    localparam int HALF_W = INT_W / 2;

    logic [INT_W-1:0] raw;
    logic [INT_W-1:0] mag;
    logic [POS_W-1:0] shamt;

    always_comb begin
        // type code bit 1 selects the full width, bit 0 selects unsigned
        if (int_type[1]) begin
            raw = value;
            neg = ~int_type[0] & value[INT_W-1];
        end else if (int_type[0]) begin
            raw = {{HALF_W{1'b0}}, value[HALF_W-1:0]};
            neg = 1'b0;
        end else begin
            raw = {{HALF_W{value[HALF_W-1]}}, value[HALF_W-1:0]};
            neg = value[HALF_W-1];
        end
        mag = neg ? (~raw + 1'b1) : raw;
    end

    always_comb begin
        msb_pos = '0;
        for (int i = 0; i < INT_W; i++) begin
            if (mag[i]) msb_pos = POS_W'(i);
        end
    end

    assign is_zero = (mag == '0);
    assign shamt   = POS_W'(INT_W - 1) - msb_pos;
    assign norm    = mag << shamt;
endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
#(
    parameter int PREC = 53
)(
    input  logic [INT_W-1:0] norm,
    input  logic [POS_W-1:0] msb_pos,
    input  logic             neg,
    input  logic [1:0]       rmode,
    output logic [PREC-1:0]  mant,
    output logic [POS_W:0]   exp_u,
    output logic             inexact,
    output logic             rnd_up
);
    localparam int GRD = INT_W - 1 - PREC;

    logic [PREC-1:0] kept;
    logic            guard;
    logic            sticky;
    logic [PREC:0]   incr;

    assign kept   = norm[INT_W-1 -: PREC];
    assign guard  = norm[GRD];
    assign sticky = |norm[GRD-1:0];
    assign inexact = guard | sticky;

    always_comb begin
        case (rmode_e'(rmode))
            RM_NEAR: rnd_up = guard & (sticky | kept[0]);
            RM_ZERO: rnd_up = 1'b0;
            RM_PINF: rnd_up = ~neg & inexact;
            default: rnd_up = neg & inexact;
        endcase
    end

    assign incr = {1'b0, kept} + {{PREC{1'b0}}, rnd_up};

    always_comb begin
        if (incr[PREC]) begin
            mant  = incr[PREC:1];
            exp_u = {1'b0, msb_pos} + 1'b1;
        end else begin
            mant  = incr[PREC-1:0];
            exp_u = {1'b0, msb_pos};
        end
    end
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
    import i2f_pkg::*;
#(
    parameter int DP_PREC = 53,
    parameter int SP_PREC = 24
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [63:0]      in_value,
    input  logic [1:0]       in_type,
    input  logic             in_single,
    input  logic [1:0]       in_rmode,
    output logic             out_valid,
    output logic [63:0]      out_result,
    output logic [4:0]       out_class,
    output logic             out_fr,
    output logic             out_fi,
    output logic             out_flag_we
);
    localparam int SP_PAD = FRAC_W - (SP_PREC - 1);

    logic             neg, is_zero;
    logic [POS_W-1:0] msb_pos;
    logic [INT_W-1:0] norm;

    logic [DP_PREC-1:0] dp_mant;
    logic [SP_PREC-1:0] sp_mant;
    logic [POS_W:0]     dp_exp, sp_exp;
    logic               dp_fi, dp_up, sp_fi, sp_up;

    conv_out_s st_d, st_q;

    i2f_norm u_norm (
        .value    (in_value),
        .int_type (in_type),
        .neg      (neg),
        .is_zero  (is_zero),
        .msb_pos  (msb_pos),
        .norm     (norm)
    );

    i2f_round #(.PREC(DP_PREC)) u_rnd_dp (
        .norm    (norm),
        .msb_pos (msb_pos),
        .neg     (neg),
        .rmode   (in_rmode),
        .mant    (dp_mant),
        .exp_u   (dp_exp),
        .inexact (dp_fi),
        .rnd_up  (dp_up)
    );

    i2f_round #(.PREC(SP_PREC)) u_rnd_sp (
        .norm    (norm),
        .msb_pos (msb_pos),
        .neg     (neg),
        .rmode   (in_rmode),
        .mant    (sp_mant),
        .exp_u   (sp_exp),
        .inexact (sp_fi),
        .rnd_up  (sp_up)
    );

    always_comb begin
        logic [POS_W:0]    e_sel;
        logic [FRAC_W-1:0] frac;
        logic              fi_sel, up_sel, we;
        st_d       = st_q;
        st_d.valid = in_valid;
        we = in_single | in_type[1];
        if (in_single) begin
            e_sel  = sp_exp;
            frac   = {sp_mant[SP_PREC-2:0], {SP_PAD{1'b0}}};
            fi_sel = sp_fi;
            up_sel = sp_up;
        end else begin
            e_sel  = dp_exp;
            frac   = dp_mant[DP_PREC-2:0];
            fi_sel = dp_fi;
            up_sel = dp_up;
        end
        if (in_valid) begin
            st_d.flag_we = we;
            if (is_zero) begin
                st_d.result = '0;
                st_d.cls    = CLS_POS_ZERO;
                st_d.fr     = 1'b0;
                st_d.fi     = 1'b0;
            end else begin
                st_d.result = {neg, EXP_W'(e_sel) + EXP_W'(EXP_BIAS), frac};
                st_d.cls    = neg ? CLS_NEG_NORM : CLS_POS_NORM;
                st_d.fr     = we & up_sel;
                st_d.fi     = we & fi_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_class   = st_q.cls;
    assign out_fr      = st_q.fr;
    assign out_fi      = st_q.fi;
    assign out_flag_we = st_q.flag_we;

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_exact_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_single && !in_type[1]) |=> (!out_flag_we && !out_fr && !out_fi));
    p_single_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_single) |=> (out_result[28:0] == 29'd0));
    p_fr_needs_fi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fr) |-> out_fi);
    p_trunc_no_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rmode == 2'b01) |=> !out_fr);
    p_zero_plus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_value == 64'd0) |=> (out_result == 64'd0 && out_class == CLS_POS_ZERO));
    p_class_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result != 64'd0) |->
        (out_class == (out_result[63] ? CLS_NEG_NORM : CLS_POS_NORM)));
endmodule

// File: tb/i2f_conv_tb.sv
`timescale 1ns/100ps
module i2f_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_value = '0;
    logic [1:0]  in_type = '0;
    logic        in_single = 1'b0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [4:0]  out_class;
    logic        out_fr, out_fi, out_flag_we;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2f_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_type(in_type), .in_single(in_single), .in_rmode(in_rmode),
        .out_valid(out_valid), .out_result(out_result), .out_class(out_class),
        .out_fr(out_fr), .out_fi(out_fi), .out_flag_we(out_flag_we)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // value-domain model: round the magnitude to PREC significant bits, then encode
    task automatic model(input logic [63:0] v, input logic [1:0] t, input logic sgl,
                         input logic [1:0] rm, output logic [63:0] r, output logic [4:0] c,
                         output logic fr, output logic fi, output logic we);
        logic        neg;
        logic [64:0] mag, ulp, rem, half, trunc, rv, sh65;
        int          prec, m, s, mr;
        logic        up;
        we = sgl | t[1];
        prec = sgl ? 24 : 53;
        case (t)
            2'd0: begin neg = v[31]; mag = neg ? (65'h1_0000_0000 - {33'd0, v[31:0]}) : {33'd0, v[31:0]}; end
            2'd1: begin neg = 1'b0; mag = {33'd0, v[31:0]}; end
            2'd2: begin neg = v[63]; mag = neg ? (65'h1_0000_0000_0000_0000 - {1'b0, v}) : {1'b0, v}; end
            default: begin neg = 1'b0; mag = {1'b0, v}; end
        endcase
        fr = 0; fi = 0;
        if (mag == 0) begin
            r = 64'd0; c = 5'b00010;
        end else begin
            m = 0;
            for (int i = 0; i < 65; i++) if (mag[i]) m = i;
            if (m < prec) begin
                rv = mag; up = 0; rem = 0;
            end else begin
                s = m - prec + 1;
                ulp = 65'd1 << s;
                rem = mag & (ulp - 65'd1);
                trunc = mag - rem;
                half = ulp >> 1;
                case (rm)
                    2'b00: up = (rem > half) || (rem == half && rem != 0 && trunc[s]);
                    2'b01: up = 0;
                    2'b10: up = !neg && rem != 0;
                    default: up = neg && rem != 0;
                endcase
                rv = up ? trunc + ulp : trunc;
            end
            fi = (rem != 0);
            fr = up;
            mr = 0;
            for (int i = 0; i < 65; i++) if (rv[i]) mr = i;
            sh65 = rv << (64 - mr);
            r = {neg, 11'(mr + 1023), sh65[63:12]};
            c = neg ? 5'b01000 : 5'b00100;
        end
    endtask

    task automatic run_vec(input string tag, input logic [63:0] v, input logic [1:0] t,
                           input logic sgl, input logic [1:0] rm);
        logic [63:0] er; logic [4:0] ec; logic efr, efi, ewe;
        model(v, t, sgl, rm, er, ec, efr, efi, ewe);
        in_valid = 1; in_value = v; in_type = t; in_single = sgl; in_rmode = rm;
        @(negedge clk);
        check("R9", "valid", {63'd0, out_valid}, 64'd1);
        check(tag, "result", out_result, er);
        check("R6", "class", {59'd0, out_class}, {59'd0, ec});
        check("R5", "fr/fi", {62'd0, out_fr, out_fi}, {62'd0, efr, efi});
        check("R2", "flag_we", {63'd0, out_flag_we}, {63'd0, ewe});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R9", "reset valid", {63'd0, out_valid}, 64'd0);
        check("R9", "reset result", out_result, 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R7: zero in every mode and both precisions
        for (int rm = 0; rm < 4; rm++)
            for (int t = 0; t < 4; t++) begin
                run_vec("R7", 64'd0, 2'(t), 1'b0, 2'(rm));
                run_vec("R7", 64'd0, 2'(t), 1'b1, 2'(rm));
            end
        // R8: most negative signed 64-bit
        run_vec("R8", 64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'b00);
        check("R8", "exact value", out_result, 64'hC3E0_0000_0000_0000);
        run_vec("R8", 64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'b10);
        // R1: upper bits ignored for 32-bit types
        run_vec("R1", 64'hDEAD_BEEF_FFFF_FFFF, 2'd0, 1'b0, 2'b00);
        check("R1", "s32 -1", out_result, 64'hBFF0_0000_0000_0000);
        run_vec("R1", 64'h1234_5678_8000_0000, 2'd0, 1'b0, 2'b11);
        run_vec("R1", 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b0, 2'b01);
        run_vec("R1", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'b01);
        // R3: carry into exponent, all modes, on all-ones u64
        for (int rm = 0; rm < 4; rm++) run_vec("R3", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'(rm));
        // R3: ties and near-ties for double
        for (int rm = 0; rm < 4; rm++) begin
            run_vec("R3", 64'h0020_0000_0000_0001, 2'd2, 1'b0, 2'(rm));
            run_vec("R3", 64'h0020_0000_0000_0003, 2'd3, 1'b0, 2'(rm));
            run_vec("R3", 64'hFFDF_FFFF_FFFF_FFFD, 2'd2, 1'b0, 2'(rm));
        end
        // R4: single-precision boundaries
        for (int rm = 0; rm < 4; rm++) begin
            run_vec("R4", 64'd16777217, 2'd0, 1'b1, 2'(rm));
            run_vec("R4", 64'hFEFF_FFFF, 2'd0, 1'b1, 2'(rm));
            run_vec("R4", 64'hFFFF_FFFF, 2'd1, 1'b1, 2'(rm));
            run_vec("R4", 64'd16777219, 2'd1, 1'b1, 2'(rm));
        end
        // R2: exact 32-bit double path leaves flags off
        run_vec("R2", 64'h0000_0000_7FFF_FFFF, 2'd0, 1'b0, 2'b10);
        run_vec("R2", 64'h0000_0000_FFFF_FFFF, 2'd1, 1'b0, 2'b00);

        // random stimulus
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] t; logic sgl; logic [1:0] rm;
            v = {$urandom, $urandom};
            if ($urandom_range(0, 2) == 0) v = v >> $urandom_range(0, 63);
            t = 2'($urandom_range(0, 3));
            sgl = 1'($urandom_range(0, 1));
            rm = 2'($urandom_range(0, 3));
            if (!sgl && !t[1]) run_vec("R2", v, t, sgl, rm);
            else if (sgl)      run_vec("R4", v, t, sgl, rm);
            else               run_vec("R3", v, t, sgl, rm);
        end

        // R9: valid drops one cycle after the request stops
        in_valid = 0;
        @(negedge clk);
        check("R9", "valid low", {63'd0, out_valid}, 64'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule